// File: doc/BRIEF.md
# Staggered Half-Slice Adder

This block is an add/subtract datapath that runs on a fast clock, nominally twice the core clock. It splits a `2*SLICE_W`-bit operation into two slices of `SLICE_W` bits. In the fast cycle after issue, the low slice produces its sum and registers its carry. In the following fast cycle, the high slice adds its operand halves plus that registered carry. The low half of every result therefore appears one fast cycle before the high half. The full result is ready two fast cycles after issue, which is one core cycle.

A dependent operation can start on the next fast cycle by asserting the chain input. Its low slice then takes operand A from the low-half bypass. One fast cycle later, its high slice takes operand A from the high-half bypass. The stagger stays intact, so an unbroken chain of dependent operations can accept a new operation every fast cycle.

A subtraction inverts operand B and forces the low slice's carry-in to 1. The only flag is the carry out of the top bit.

Top module: `stag_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the first cycle after it, `lo_valid`, `hi_valid`, `result`, `lo_bypass` and `carry_out` are all 0.
- R2: `lo_valid` is high for exactly one fast cycle, the cycle after each edge that samples `issue_valid` high. In that cycle `lo_bypass` holds the low `SLICE_W` bits of the operation's result.
- R3: `hi_valid` is high for exactly the one cycle that follows each `lo_valid` cycle. In that cycle, for an add, `{carry_out, result}` equals the `2*SLICE_W+1`-bit sum of A and B.
- R4: When `issue_sub` is 1, `result` equals A minus B modulo 2^(2*SLICE_W). `carry_out` is 1 exactly when A is greater than or equal to B, both taken as unsigned.
- R5: A carry out of the low slice propagates into the high slice. For example, adding 1 to a value whose low slice is all ones increments the high slice.
- R6: When `issue_chain` is 1, operand A is replaced by the full result of the most recently issued operation. This holds whether the two operations are back to back or separated by idle cycles, and `opnd_a` is then ignored.
- R7: While `lo_valid` is low, `lo_bypass` keeps its last value. While `hi_valid` is low, `result` and `carry_out` keep their last values.
- R8: Operations issued on consecutive fast cycles each produce their own result, in issue order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the core frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Operation presented this cycle |
| issue_sub | input | 1 | 1 = subtract B from A, 0 = add |
| issue_chain | input | 1 | 1 = operand A is the previous operation's result |
| opnd_a | input | 2*SLICE_W | Operand A |
| opnd_b | input | 2*SLICE_W | Operand B |
| lo_valid | output | 1 | Low-half result is present on `lo_bypass` |
| lo_bypass | output | SLICE_W | Low-half result, available early to dependent operations |
| hi_valid | output | 1 | Full result is present |
| result | output | 2*SLICE_W | Full result |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a back-to-back dependent chain. In it, the high slice of one operation reads the high bypass in the same cycle that the previous operation's high half is being written, while a third operation enters the low slice. The bench reaches this state with long runs of single-cycle issues that have `issue_chain` set and a mix of add and subtract, interleaved with idle gaps. Around this, it sweeps every add operand pair and a dense grid of subtractions on an 8-bit configuration, so every low-slice carry pattern reaches the high slice.

// File: rtl/stag_pkg.sv
// Shared definitions for the staggered half-slice adder.
// Assumes nothing beyond a two-slice datapath.
package stag_pkg;
    // Operation kind decoded from the issue inputs
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_kind_t;

    // Default slice width
    localparam int SLICE_W_DEF = 16;
endpackage

// File: rtl/slice_add.sv
// Combinational slice adder: sum = a + b + cin, with carry out.
// Assumes that any operand conditioning (inversion) is done upstream.
module slice_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int WX = W + 1;

    logic [WX-1:0] wide;

    // Add with carry-in at one extra bit of width
    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{(WX-1){1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
    end
endmodule

// File: rtl/opnd_cond.sv
// Conditional bitwise inversion of an operand, used for subtraction.
// Assumes inv is constant for the whole word.
module opnd_cond #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         inv,
    output logic [W-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // One XOR per bit
            assign dout[i] = din[i] ^ inv;
        end
    endgenerate
endmodule

// File: rtl/lo_stage.sv
// Low-slice stage: adds the low operand halves in the issue cycle and
// registers the sum, the carry and the high operand halves for the next stage.
// Assumes chain selects its own last registered low sum as operand A.
module lo_stage
    import stag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_valid,
    input  logic         issue_sub,
    input  logic         issue_chain,
    input  logic [W-1:0] a_lo,
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] b_lo,
    input  logic [W-1:0] b_hi,
    output logic         lo_valid_q,
    output logic [W-1:0] lo_sum_q,
    output logic         lo_carry_q,
    output logic [W-1:0] a_hi_q,
    output logic [W-1:0] b_hi_q,
    output logic         chain_q
);
    op_kind_t     kind;
    logic [W-1:0] b_lo_c;
    logic [W-1:0] b_hi_c;
    logic [W-1:0] a_lo_eff;
    logic [W-1:0] sum_c;
    logic         cout_c;

    // Decode the operation kind
    always_comb kind = issue_sub ? OP_SUB : OP_ADD;

    // Pick operand A low half: own bypass when chained
    always_comb a_lo_eff = issue_chain ? lo_sum_q : a_lo;

    opnd_cond #(.W(W)) u_inv_lo (
        .din (b_lo),
        .inv (kind == OP_SUB),
        .dout(b_lo_c)
    );

    opnd_cond #(.W(W)) u_inv_hi (
        .din (b_hi),
        .inv (kind == OP_SUB),
        .dout(b_hi_c)
    );

    slice_add #(.W(W)) u_add (
        .a   (a_lo_eff),
        .b   (b_lo_c),
        .cin (kind == OP_SUB),
        .sum (sum_c),
        .cout(cout_c)
    );

    // Valid pulse for the low half
    always_ff @(posedge clk) begin
        if (!rst_n) lo_valid_q <= 1'b0;
        else        lo_valid_q <= issue_valid;
    end

    // Capture low result and stage high operands on issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_sum_q   <= '0;
            lo_carry_q <= 1'b0;
            a_hi_q     <= '0;
            b_hi_q     <= '0;
            chain_q    <= 1'b0;
        end else if (issue_valid) begin
            lo_sum_q   <= sum_c;
            lo_carry_q <= cout_c;
            a_hi_q     <= a_hi;
            b_hi_q     <= b_hi_c;
            chain_q    <= issue_chain;
        end
    end
endmodule

// File: rtl/hi_stage.sv
// High-slice stage: adds the staged high operand halves plus the registered
// low-slice carry one fast cycle after the low slice, and assembles the result.
// Assumes chain selects its own last registered high sum as operand A.
module hi_stage #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lo_valid_q,
    input  logic [W-1:0]   lo_sum_q,
    input  logic           lo_carry_q,
    input  logic [W-1:0]   a_hi_q,
    input  logic [W-1:0]   b_hi_q,
    input  logic           chain_q,
    output logic           hi_valid_q,
    output logic [2*W-1:0] res_q,
    output logic           cout_q
);
    localparam int W2 = 2 * W;

    logic [W-1:0] a_hi_eff;
    logic [W-1:0] sum_c;
    logic         cout_c;

    // Pick operand A high half: high bypass when chained
    always_comb a_hi_eff = chain_q ? res_q[W2-1:W] : a_hi_q;

    slice_add #(.W(W)) u_add (
        .a   (a_hi_eff),
        .b   (b_hi_q),
        .cin (lo_carry_q),
        .sum (sum_c),
        .cout(cout_c)
    );

    // Valid pulse for the high half
    always_ff @(posedge clk) begin
        if (!rst_n) hi_valid_q <= 1'b0;
        else        hi_valid_q <= lo_valid_q;
    end

    // Assemble full result and carry when the low half is ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            cout_q <= 1'b0;
        end else if (lo_valid_q) begin
            res_q  <= {sum_c, lo_sum_q};
            cout_q <= cout_c;
        end
    end
endmodule

// File: rtl/stag_adder.sv
// Top: staggered two-slice add/subtract on a double-rate clock.
// Assumes clk is the fast clock; one issue may be accepted every cycle.
module stag_adder
    import stag_pkg::*;
#(
    parameter int SLICE_W = SLICE_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_valid,
    input  logic                   issue_sub,
    input  logic                   issue_chain,
    input  logic [2*SLICE_W-1:0]   opnd_a,
    input  logic [2*SLICE_W-1:0]   opnd_b,
    output logic                   lo_valid,
    output logic [SLICE_W-1:0]     lo_bypass,
    output logic                   hi_valid,
    output logic [2*SLICE_W-1:0]   result,
    output logic                   carry_out
);
    localparam int W2 = 2 * SLICE_W;

    logic               lo_carry_q;
    logic [SLICE_W-1:0] a_hi_q;
    logic [SLICE_W-1:0] b_hi_q;
    logic               chain_q;

    lo_stage #(.W(SLICE_W)) u_lo (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .issue_sub  (issue_sub),
        .issue_chain(issue_chain),
        .a_lo       (opnd_a[SLICE_W-1:0]),
        .a_hi       (opnd_a[W2-1:SLICE_W]),
        .b_lo       (opnd_b[SLICE_W-1:0]),
        .b_hi       (opnd_b[W2-1:SLICE_W]),
        .lo_valid_q (lo_valid),
        .lo_sum_q   (lo_bypass),
        .lo_carry_q (lo_carry_q),
        .a_hi_q     (a_hi_q),
        .b_hi_q     (b_hi_q),
        .chain_q    (chain_q)
    );

    hi_stage #(.W(SLICE_W)) u_hi (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_valid_q(lo_valid),
        .lo_sum_q  (lo_bypass),
        .lo_carry_q(lo_carry_q),
        .a_hi_q    (a_hi_q),
        .b_hi_q    (b_hi_q),
        .chain_q   (chain_q),
        .hi_valid_q(hi_valid),
        .res_q     (result),
        .cout_q    (carry_out)
    );
endmodule

// File: rtl/stag_adder_chk.sv
// Checker for stag_adder: timing of the half-result pulses, hold behaviour
// and arithmetic of non-chained operations. Assumes reset lasts two or more edges.
module stag_adder_chk #(
    parameter int SLICE_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic                 issue_sub,
    input logic                 issue_chain,
    input logic [2*SLICE_W-1:0] opnd_a,
    input logic [2*SLICE_W-1:0] opnd_b,
    input logic                 lo_valid,
    input logic [SLICE_W-1:0]   lo_bypass,
    input logic                 hi_valid,
    input logic [2*SLICE_W-1:0] result,
    input logic                 carry_out
);
    localparam int W2 = 2 * SLICE_W;

    a_r2_lo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> lo_valid);
    a_r2_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !lo_valid);
    a_r3_hi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |=> hi_valid);
    a_r3_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_valid |=> !hi_valid);
    a_r7_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_valid |-> $stable(lo_bypass));
    a_r7_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_valid |-> ($stable(result) && $stable(carry_out)));
    a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid && !$past(issue_sub, 2) && !$past(issue_chain, 2)) |->
        ({carry_out, result} == ({1'b0, $past(opnd_a, 2)} + {1'b0, $past(opnd_b, 2)})));
    a_r4_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid && $past(issue_sub, 2) && !$past(issue_chain, 2)) |->
        ((carry_out == ($past(opnd_a, 2) >= $past(opnd_b, 2))) &&
         (result == W2'($past(opnd_a, 2) - $past(opnd_b, 2)))));
endmodule

bind stag_adder stag_adder_chk #(.SLICE_W(SLICE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_sub  (issue_sub),
    .issue_chain(issue_chain),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .lo_valid   (lo_valid),
    .lo_bypass  (lo_bypass),
    .hi_valid   (hi_valid),
    .result     (result),
    .carry_out  (carry_out)
);

// File: tb/tb_stag_adder.sv
// Bench: exhaustive add sweep, subtract grid and chained runs on an 8-bit build.
module tb_stag_adder;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;
    localparam int W2 = 2 * SW;
    localparam int RING = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic          issue_sub = 1'b0;
    logic          issue_chain = 1'b0;
    logic [W2-1:0] opnd_a = '0;
    logic [W2-1:0] opnd_b = '0;
    logic          lo_valid;
    logic [SW-1:0] lo_bypass;
    logic          hi_valid;
    logic [W2-1:0] result;
    logic          carry_out;

    int checks = 0;
    int fails = 0;
    int issued = 0;
    int lo_seen = 0;
    int hi_seen = 0;
    bit done = 1'b0;

    logic [W2:0]   exp_q [RING];
    string         tag_q [RING];
    logic [W2-1:0] last_res = '0;

    stag_adder #(.SLICE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_sub(issue_sub), .issue_chain(issue_chain),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .lo_valid(lo_valid),
        .lo_bypass(lo_bypass), .hi_valid(hi_valid), .result(result),
        .carry_out(carry_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record one check
    task automatic check(input bit ok, input string req, input logic [W2:0] act,
                         input logic [W2:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one operation for one cycle (called right after a negedge)
    task automatic issue(input logic [W2-1:0] a, input logic [W2-1:0] b,
                         input bit sub, input bit chain, input string req);
        logic [W2-1:0] ae;
        logic [W2:0]   e;
        ae = chain ? last_res : a;
        if (sub) e = {1'b0, ae} + {1'b0, ~b} + {{W2{1'b0}}, 1'b1};
        else     e = {1'b0, ae} + {1'b0, b};
        exp_q[issued % RING] = e;
        tag_q[issued % RING] = req;
        last_res = e[W2-1:0];
        issued++;
        issue_valid = 1'b1; issue_sub = sub; issue_chain = chain;
        opnd_a = a; opnd_b = b;
        @(negedge clk);
        issue_valid = 1'b0; issue_sub = 1'b0; issue_chain = 1'b0;
    endtask

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (lo_valid) begin
                if (lo_seen >= issued)
                    check(1'b0, "R2 spurious lo_valid", 1, 0);
                else
                    check(lo_bypass == exp_q[lo_seen % RING][SW-1:0],
                          {"R2 ", tag_q[lo_seen % RING]},
                          {{(W2+1-SW){1'b0}}, lo_bypass},
                          {{(W2+1-SW){1'b0}}, exp_q[lo_seen % RING][SW-1:0]});
                lo_seen++;
            end
            if (hi_valid) begin
                if (hi_seen >= lo_seen - (lo_valid ? 1 : 0))
                    check(1'b0, "R3 hi_valid without prior lo_valid", 1, 0);
                else
                    check({carry_out, result} == exp_q[hi_seen % RING],
                          {"R8 ", tag_q[hi_seen % RING]},
                          {carry_out, result}, exp_q[hi_seen % RING]);
                hi_seen++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({lo_valid, hi_valid, carry_out} == 3'b000, "R1 valids/carry", {6'd0, lo_valid, hi_valid, carry_out}, 0);
        check({result, lo_bypass} == '0, "R1 data", {1'b0, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({lo_valid, hi_valid} == 2'b00 && result == '0, "R1 after release", {1'b0, result}, 0);

        // R5: low-slice carry into high slice
        issue(8'h0F, 8'h01, 1'b0, 1'b0, "R5 carry 0F+01");
        issue(8'hFF, 8'h01, 1'b0, 1'b0, "R5 carry FF+01");
        repeat (3) @(negedge clk);

        // R3/R8: exhaustive add, back to back
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                issue(W2'(a), W2'(b), 1'b0, 1'b0, "R3 add sweep");

        // R4: subtract grid
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
                issue(W2'(a), W2'(b), 1'b1, 1'b0, "R4 sub grid");
        issue(8'h10, 8'h10, 1'b1, 1'b0, "R4 sub equal");
        issue(8'h00, 8'h01, 1'b1, 1'b0, "R4 sub borrow");
        repeat (3) @(negedge clk);

        // R6: chains, back to back and with gaps; opnd_a is junk when chained
        issue(8'h3C, 8'h0D, 1'b0, 1'b0, "R6 chain head");
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 1103515245 + 12345;
            issue(W2'(seed >>> 8), W2'(seed >>> 16), seed[3], seed[5] | seed[6],
                  "R6 chain run");
            if (seed[9:7] == 3'b000) repeat (seed[11:10]) @(negedge clk);
        end
        repeat (4) @(negedge clk);

        // R7: idle hold
        check({carry_out, result} == exp_q[(issued - 1) % RING], "R7 result hold",
              {carry_out, result}, exp_q[(issued - 1) % RING]);
        check(lo_bypass == last_res[SW-1:0], "R7 lo hold", {5'd0, lo_bypass}, {5'd0, last_res[SW-1:0]});
        check({lo_valid, hi_valid} == 2'b00, "R7 idle valids", {7'd0, lo_valid, hi_valid}, 0);
        // R2/R3: one pulse per issue on each half
        check(lo_seen == issued, "R2 lo pulse count", W2'(lo_seen), W2'(issued));
        check(hi_seen == issued, "R3 hi pulse count", W2'(hi_seen), W2'(issued));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule